// File: doc/BRIEF.md
# Pointer-Windowed Configuration Register Bank

This block stores the configuration of an I2C controller core: its own bus address, a timeout count, a bus-speed mode and the two SCL half-period counts. The host does not address these registers directly. It owns two byte locations: a pointer that picks one internal register, and a window through which the picked register is read or written. `host_sel` chooses between the two, `host_we` qualifies a write, and `host_rdata` shows the selected location with no delay.

One internal index is a reset entry. A small key detector watches window writes to that index. The byte pair 0xA5 followed by 0x5A produces a single-cycle `core_rst` pulse. That pulse resets the bus engine outside this block and returns every configuration register to its default, so software must program mode and SCL timing again. The pointer keeps its value.

The key detector has three states. KEY_IDLE moves to KEY_ARMED on a window write of 0xA5 to the reset entry. KEY_ARMED moves to KEY_FIRE on a window write of 0x5A to the reset entry. Any other window write returns KEY_ARMED to KEY_IDLE. Pointer writes do not change KEY_ARMED. KEY_FIRE drives `core_rst` for one cycle and always returns to KEY_IDLE. A window write made during KEY_FIRE is discarded.

Top module: `cfg_bank_top`

## Requirements
- R1: A write with `host_sel`=0 stores bits [2:0] in the pointer. A read with `host_sel`=0 returns the pointer on bits [2:0] and zeros on bits [7:3].
- R2: A write with `host_sel`=1 stores the byte in the register at the pointer index. The mapping is: 0 own address, 1 timeout, 2 mode, 3 SCL low count, 4 SCL high count. A read with `host_sel`=1 returns that register, and its dedicated output port shows the same value from the cycle after the write.
- R3: After `rst_n` is released, the pointer is 0 and the defaults are: own address 0x00, timeout 0xFF, mode 0x00, SCL low 0x9D, SCL high 0x86. `core_rst` is low.
- R4: A window write of 0xA5 to index 5, then a window write of 0x5A to index 5, makes `core_rst` high for exactly the one cycle after the second write's clock edge.
- R5: After 0xA5, any window write to index 5 of a byte other than 0x5A clears the detector. A following 0x5A then produces no pulse.
- R6: After 0xA5, a window write to any other index clears the detector. A later 0x5A to index 5 produces no pulse, and the write to the other index takes effect.
- R7: The clock edge that ends the `core_rst` cycle sets all five configuration registers to their R3 defaults. The pointer keeps its value.
- R8: Index 5 and indexes 6 and 7 read as 0x00. Window writes to indexes 6 and 7 change no output.
- R9: A value written to the own address reads back unchanged after the timeout register is written.
- R10: Pointer writes between the two key bytes do not clear the detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | 0 selects the pointer, 1 selects the data window |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Selected location, combinational |
| own_addr | output | 8 | Own bus address |
| timeout_val | output | 8 | Timeout count |
| bus_mode | output | 8 | Bus-speed mode |
| scl_low | output | 8 | SCL low-period count |
| scl_high | output | 8 | SCL high-period count |
| core_rst | output | 1 | One-cycle soft reset pulse |

## Verification
Timing of each result:
- A register write is visible on `host_rdata` and on its output port after one clock edge.
- `core_rst` rises one edge after the 0x5A write.
- The defaults return one edge later still.

Every host access is driven on a falling edge and held for one rising edge. The write task returns at the next falling edge, and checks sample there, half a period away from any update. The pulse is checked high at that point and low one falling edge later. The registers are checked for their defaults at that same later point. A pulse counter sampled on rising edges shows that the rejected key sequences produce no pulse at all.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
    parameter int DATA_W = 8;
    parameter int PTR_W  = 3;
    parameter int N_CFG  = 5;

    localparam logic [PTR_W-1:0] IDX_OWN  = 3'd0;
    localparam logic [PTR_W-1:0] IDX_TMO  = 3'd1;
    localparam logic [PTR_W-1:0] IDX_MODE = 3'd2;
    localparam logic [PTR_W-1:0] IDX_LOW  = 3'd3;
    localparam logic [PTR_W-1:0] IDX_HIGH = 3'd4;
    localparam logic [PTR_W-1:0] IDX_RST  = 3'd5;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 8'hA5;
    localparam logic [DATA_W-1:0] KEY_SECOND = 8'h5A;

    typedef enum logic [1:0] {
        KEY_IDLE  = 2'd0,
        KEY_ARMED = 2'd1,
        KEY_FIRE  = 2'd2
    } key_state_t;

    function automatic logic [DATA_W-1:0] cfg_default(input int idx);
        case (idx)
            0:       return 8'h00;
            1:       return 8'hFF;
            2:       return 8'h00;
            3:       return 8'h9D;
            4:       return 8'h86;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
    import cfg_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_we,
    input  logic [PTR_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic              pulse
);
    key_state_t state, state_nx;
    logic       hit_rst;

    assign hit_rst = win_we && (idx == IDX_RST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= KEY_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            KEY_IDLE: begin
                if (hit_rst && wdata == KEY_FIRST) state_nx = KEY_ARMED;
            end
            KEY_ARMED: begin
                if (hit_rst && wdata == KEY_SECOND) state_nx = KEY_FIRE;
                else if (win_we)                    state_nx = KEY_IDLE;
            end
            KEY_FIRE: state_nx = KEY_IDLE;
            default:  state_nx = KEY_IDLE;
        endcase
    end

    always_comb begin
        unique case (state)
            KEY_FIRE: pulse = 1'b1;
            default:  pulse = 1'b0;
        endcase
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse); // R4
    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |-> $past(win_we && idx == IDX_RST && wdata == KEY_SECOND)); // R4
endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file
    import cfg_bank_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    soft_rst,
    input  logic                    win_we,
    input  logic [PTR_W-1:0]        idx,
    input  logic [DATA_W-1:0]       wdata,
    output logic [N_CFG*DATA_W-1:0] cfg_flat,
    output logic [DATA_W-1:0]       rd_val
);
    for (genvar i = 0; i < N_CFG; i++) begin : g_reg
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           q <= cfg_default(i);
            else if (soft_rst)                    q <= cfg_default(i);
            else if (win_we && idx == PTR_W'(i))  q <= wdata;
        end
        assign cfg_flat[i*DATA_W +: DATA_W] = q;
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < N_CFG; i++) begin
            if (idx == PTR_W'(i)) rd_val = cfg_flat[i*DATA_W +: DATA_W];
        end
    end

    AST_DEFAULTS_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_rst) |-> (cfg_flat[DATA_W-1:0] == 8'h00 &&
                             cfg_flat[2*DATA_W-1:DATA_W] == 8'hFF &&
                             cfg_flat[4*DATA_W-1:3*DATA_W] == 8'h9D)); // R7
endmodule

// File: rtl/cfg_bank_top.sv
module cfg_bank_top
    import cfg_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic              host_sel,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic [DATA_W-1:0] own_addr,
    output logic [DATA_W-1:0] timeout_val,
    output logic [DATA_W-1:0] bus_mode,
    output logic [DATA_W-1:0] scl_low,
    output logic [DATA_W-1:0] scl_high,
    output logic              core_rst
);
    logic [PTR_W-1:0]        ptr;
    logic                    ptr_we;
    logic                    win_we;
    logic [N_CFG*DATA_W-1:0] cfg_flat;
    logic [DATA_W-1:0]       win_rd;

    assign ptr_we = host_we && !host_sel;
    assign win_we = host_we && host_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ptr <= '0;
        else if (ptr_we) ptr <= host_wdata[PTR_W-1:0];
    end

    cfg_key_fsm i_key (
        .clk   (clk),
        .rst_n (rst_n),
        .win_we(win_we),
        .idx   (ptr),
        .wdata (host_wdata),
        .pulse (core_rst)
    );

    cfg_reg_file i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_rst(core_rst),
        .win_we  (win_we && !core_rst),
        .idx     (ptr),
        .wdata   (host_wdata),
        .cfg_flat(cfg_flat),
        .rd_val  (win_rd)
    );

    assign own_addr    = cfg_flat[32'(IDX_OWN)*DATA_W  +: DATA_W];
    assign timeout_val = cfg_flat[32'(IDX_TMO)*DATA_W  +: DATA_W];
    assign bus_mode    = cfg_flat[32'(IDX_MODE)*DATA_W +: DATA_W];
    assign scl_low     = cfg_flat[32'(IDX_LOW)*DATA_W  +: DATA_W];
    assign scl_high    = cfg_flat[32'(IDX_HIGH)*DATA_W +: DATA_W];

    assign host_rdata = host_sel ? win_rd : {{(DATA_W-PTR_W){1'b0}}, ptr};

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ptr_we) |-> $stable(ptr)); // R7
    AST_RST_ENTRY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && ptr >= IDX_RST) |-> host_rdata == '0); // R8
endmodule

// File: tb/test_cfg_bank_top.sv
module test_cfg_bank_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_we = 1'b0;
    logic       host_sel = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata, own_addr, timeout_val, bus_mode, scl_low, scl_high;
    logic       core_rst;
    int         total = 0;
    int         bad = 0;
    int         pulses = 0;

    always #5 clk = ~clk;

    cfg_bank_top i_cfg_bank_top (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .own_addr(own_addr),
        .timeout_val(timeout_val), .bus_mode(bus_mode), .scl_low(scl_low),
        .scl_high(scl_high), .core_rst(core_rst)
    );

    always @(posedge clk) if (core_rst) pulses <= pulses + 1;

    // {index, written byte, expected window readback}
    localparam logic [18:0] VEC [8] = '{
        {3'd0, 8'h42, 8'h42}, {3'd1, 8'h10, 8'h10}, {3'd2, 8'h03, 8'h03},
        {3'd3, 8'h20, 8'h20}, {3'd4, 8'h11, 8'h11}, {3'd6, 8'h77, 8'h00},
        {3'd7, 8'h33, 8'h00}, {3'd5, 8'h12, 8'h00}
    };

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        host_sel = sel; host_we = 1'b1; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        host_sel = sel; #1; v = host_rdata;
    endtask

    task automatic chk_defaults(input string req);
        chk(req, own_addr, 8'h00); chk(req, timeout_val, 8'hFF);
        chk(req, bus_mode, 8'h00); chk(req, scl_low, 8'h9D);
        chk(req, scl_high, 8'h86);
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog got=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 reset state
        rd(1'b0, v); chk("R3 ptr", v, 8'h00);
        chk_defaults("R3");
        chk("R3 pulse", {7'd0, core_rst}, 8'h00);

        // R2 R8 table walk
        for (int i = 0; i < 8; i++) begin
            wr(1'b0, {5'd0, VEC[i][18:16]});
            rd(1'b0, v); chk("R1 ptr readback", v, {5'd0, VEC[i][18:16]});
            wr(1'b1, VEC[i][15:8]);
            rd(1'b1, v); chk("R2 R8 window", v, VEC[i][7:0]);
        end
        chk("R2 own", own_addr, 8'h42);   chk("R8 tmo", timeout_val, 8'h10);
        chk("R2 mode", bus_mode, 8'h03);  chk("R8 low", scl_low, 8'h20);
        chk("R8 high", scl_high, 8'h11);
        chk("R8 pulse", 8'(pulses), 8'd0);

        // R1 upper bits ignored
        wr(1'b0, 8'hFB); rd(1'b0, v); chk("R1 mask", v, 8'h03);

        // R9 own address survives timeout write
        wr(1'b0, 8'h00); wr(1'b1, 8'hAA);
        wr(1'b0, 8'h01); wr(1'b1, 8'h00);
        wr(1'b0, 8'h00); rd(1'b1, v); chk("R9", v, 8'hAA);

        // R5 wrong second byte
        wr(1'b0, 8'h05); p0 = pulses;
        wr(1'b1, 8'hA5); wr(1'b1, 8'h12); wr(1'b1, 8'h5A);
        @(negedge clk); chk("R5 no pulse", 8'(pulses - p0), 8'd0);

        // R6 other entry in between
        wr(1'b1, 8'hA5);
        wr(1'b0, 8'h02); wr(1'b1, 8'h07);
        wr(1'b0, 8'h05); wr(1'b1, 8'h5A);
        @(negedge clk); chk("R6 no pulse", 8'(pulses - p0), 8'd0);
        chk("R6 mode written", bus_mode, 8'h07);

        // R10 pointer writes keep detector armed; R4 pulse timing
        wr(1'b1, 8'hA5);
        wr(1'b0, 8'h03); wr(1'b0, 8'h05);
        wr(1'b1, 8'h5A);
        chk("R4 R10 pulse high", {7'd0, core_rst}, 8'h01);
        @(negedge clk);
        chk("R4 pulse low", {7'd0, core_rst}, 8'h00);
        chk("R4 one pulse", 8'(pulses - p0), 8'd1);
        // R7 defaults back, pointer kept
        chk_defaults("R7");
        rd(1'b0, v); chk("R7 ptr kept", v, 8'h05);

        // R4 plain sequence again after a soft reset
        wr(1'b1, 8'hA5); wr(1'b1, 8'h5A);
        chk("R4 second pulse", {7'd0, core_rst}, 8'h01);
        @(negedge clk);
        chk("R4 count", 8'(pulses - p0), 8'd2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule